// File: doc/BRIEF.md
# Inbound Address Translation Window Unit

This block translates addresses arriving from the PCIe side into CPU-side addresses through a small, fixed set of independent windows. Each window holds a base, a limit, a target address, a three-bit type code and an enable bit. Software programs and reads all of these through a simple write-strobe and combinational read-back interface. A lookup presented on `inValid`/`inAddr` returns one cycle later. The result carries the translated address, a hit or miss flag and the index of the winning window. On a miss the address passes through untouched.

Every window has a fixed granule, set by the `MIN_REGION` parameter. The low bits of the limit cannot be written and always read as ones, so a mapping always covers whole granules and a short size grows to the next granule boundary. A window that breaks the placement rules is reported on its `cfgErr` bit and never translates. The rules are: base and target aligned to the granule, and base and limit equal in every bit at or above `REGION_LIMIT_LOG2`. When enabled windows overlap, the lowest index wins.

Top module: `xlat_window_unit`

## Requirements
- R1: After reset every window is disabled, base, target and control read as 0, the limit reads as the granule mask (0x00000FFF for the default 4 KiB granule), no `cfgErr` bit is set and `outValid` is 0.
- R2: Field select codes are 0 = base, 1 = limit, 2 = target, 3 = control (bit 0 enable, bits 3:1 type). Base, target and control read back exactly as written. The limit reads back with its low log2(MIN_REGION) bits forced to one. The granule mask is 0xFFFF for 64 KiB, 0x7FFF for 32 KiB, 0x3FFF for 16 KiB, 0x1FFF for 8 KiB, 0xFFF for 4 KiB, and 0xFFFF for any other value.
- R3: For an enabled window without a configuration error whose base <= addr <= read-back limit, the cycle after `inValid` shows `outValid`=1, `outHit`=1, `outMiss`=0, `outWin` = that window's index and `outAddr` = target + (addr - base), modulo 2^ADDR_W.
- R4: When no window qualifies, the cycle after `inValid` shows `outHit`=0, `outMiss`=1 and `outAddr` equal to the input address. `outValid` is 0 in any cycle that follows a cycle without `inValid`.
- R5: When several qualifying windows contain the address, the lowest index is reported and its mapping is used.
- R6: `cfgErr[i]` is 1 exactly when window i has base or target not aligned to the granule, or base and limit differ in any bit at or above `REGION_LIMIT_LOG2` (default 20). Such a window never produces a hit.
- R7: A window with its enable bit at 0 never produces a hit.
- R8: A write whose window index is NUM_WIN or above changes no register. A read of such an index returns 0.
- R9: A register write takes effect for lookups presented in the cycle after the write. A lookup presented in the same cycle as the write uses the old contents.
- R10: A limit written with nonzero low bits still maps up to the end of its granule. The address one past that end misses.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrWin | input | SEL_W | Window index of the write |
| wrSel | input | 2 | Field selected for the write |
| wrData | input | ADDR_W | Write data |
| rdWin | input | SEL_W | Window index of the read |
| rdSel | input | 2 | Field selected for the read |
| rdData | output | ADDR_W | Combinational read data |
| cfgErr | output | NUM_WIN | Per-window configuration error |
| inValid | input | 1 | Lookup request valid |
| inAddr | input | ADDR_W | PCIe-side address to translate |
| outValid | output | 1 | Lookup result valid |
| outAddr | output | ADDR_W | Translated or passed-through address |
| outHit | output | 1 | A window matched |
| outMiss | output | 1 | No window matched |
| outWin | output | IDX_W | Index of the matching window |

## Verification
A corrupted base, limit or target register shows up at the ports in two ways. It appears at once in the combinational read-back. On the next lookup it appears as a shifted translated address or a wrong hit boundary. The bench sweeps each window's edges one below, at and one above both ends, and steps coarsely across the whole programmed space. A stuck enable, a wrong error flag or a broken priority chain then changes `outHit` or `outWin` in the cycle after the affected lookup. A latency or write-ordering fault shows as a result that uses the old or the new register contents in the wrong cycle.

// File: rtl/atu_pkg.sv
package atu_pkg;

  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_LIMIT  = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_CTRL   = 2'd3
  } fieldSel_e;

  // Field strobes sent from control to the register datapath
  typedef struct packed {
    logic base;
    logic limit;
    logic target;
    logic ctrl;
  } fieldStrobe_t;

  // Number of hardwired ones at the bottom of every limit
  function automatic int granuleBits(input int minRegion);
    case (minRegion)
      65536:   return 16;
      32768:   return 15;
      16384:   return 14;
      8192:    return 13;
      4096:    return 12;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/atu_ctrl.sv
module atu_ctrl
  import atu_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int SEL_W   = 3
) (
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrWin,
  input  logic [1:0]         wrSel,
  output fieldStrobe_t       strobe,
  output logic [NUM_WIN-1:0] winOneHot
);

  always_comb begin
    strobe        = '0;
    strobe.base   = wrEn && (wrSel == SEL_BASE);
    strobe.limit  = wrEn && (wrSel == SEL_LIMIT);
    strobe.target = wrEn && (wrSel == SEL_TARGET);
    strobe.ctrl   = wrEn && (wrSel == SEL_CTRL);
  end

  // Indices at or above NUM_WIN select nothing
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_dec
    assign winOneHot[i] = (wrWin == SEL_W'(i));
  end

endmodule

// File: rtl/atu_regfile.sv
module atu_regfile
  import atu_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 32,
  parameter int GRAN     = 12,
  parameter int LIM_LOG2 = 20,
  parameter int SEL_W    = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  fieldStrobe_t                    strobe,
  input  logic [NUM_WIN-1:0]              winOneHot,
  input  logic [ADDR_W-1:0]               wrData,
  input  logic [SEL_W-1:0]                rdWin,
  input  logic [1:0]                      rdSel,
  output logic [ADDR_W-1:0]               rdData,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  baseArr,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  limitArr,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  targetArr,
  output logic [NUM_WIN-1:0]              enArr,
  output logic [NUM_WIN-1:0]              errArr
);

  localparam int TYPE_W = 3;

  logic [NUM_WIN-1:0][TYPE_W-1:0] typeArr;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [ADDR_W-1:0]      baseQ;
    logic [ADDR_W-1:0]      targetQ;
    logic [ADDR_W-1:GRAN]   limitHiQ;
    logic                   enQ;
    logic [TYPE_W-1:0]      typeQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ    <= '0;
        targetQ  <= '0;
        limitHiQ <= '0;
        enQ      <= 1'b0;
        typeQ    <= '0;
      end else if (winOneHot[i]) begin
        if (strobe.base)   baseQ    <= wrData;
        if (strobe.target) targetQ  <= wrData;
        if (strobe.limit)  limitHiQ <= wrData[ADDR_W-1:GRAN];
        if (strobe.ctrl) begin
          enQ   <= wrData[0];
          typeQ <= wrData[TYPE_W:1];
        end
      end
    end

    assign baseArr[i]   = baseQ;
    assign targetArr[i] = targetQ;
    assign limitArr[i]  = {limitHiQ, {GRAN{1'b1}}};
    assign enArr[i]     = enQ;
    assign typeArr[i]   = typeQ;
    assign errArr[i]    = (|baseQ[GRAN-1:0]) || (|targetQ[GRAN-1:0]) ||
                          (baseQ[ADDR_W-1:LIM_LOG2] != limitHiQ[ADDR_W-1:LIM_LOG2]);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (rdWin == SEL_W'(i)) begin
        case (rdSel)
          SEL_BASE:   rdData = baseArr[i];
          SEL_LIMIT:  rdData = limitArr[i];
          SEL_TARGET: rdData = targetArr[i];
          default:    rdData = {{(ADDR_W-TYPE_W-1){1'b0}}, typeArr[i], enArr[i]};
        endcase
      end
    end
  end

endmodule

// File: rtl/atu_lookup.sv
module atu_lookup #(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] baseArr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] limitArr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] targetArr,
  input  logic [NUM_WIN-1:0]             enArr,
  input  logic [NUM_WIN-1:0]             errArr,
  input  logic                           inValid,
  input  logic [ADDR_W-1:0]              inAddr,
  output logic                           outValid,
  output logic [ADDR_W-1:0]              outAddr,
  output logic                           outHit,
  output logic                           outMiss,
  output logic [IDX_W-1:0]               outWin
);

  logic [NUM_WIN-1:0] match;
  logic               anyHit;
  logic [IDX_W-1:0]   hitIdx;
  logic [ADDR_W-1:0]  xlatAddr;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign match[i] = enArr[i] && !errArr[i] &&
                      (inAddr >= baseArr[i]) && (inAddr <= limitArr[i]);
  end

  // Lowest index has priority: scan downward so it is assigned last
  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
    xlatAddr = anyHit ? targetArr[hitIdx] + (inAddr - baseArr[hitIdx]) : inAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outHit   <= 1'b0;
      outMiss  <= 1'b0;
      outWin   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outAddr <= xlatAddr;
        outHit  <= anyHit;
        outMiss <= !anyHit;
        outWin  <= hitIdx;
      end
    end
  end

endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
  import atu_pkg::*;
#(
  parameter int NUM_WIN           = 4,
  parameter int ADDR_W            = 32,
  parameter int MIN_REGION        = 4096,
  parameter int REGION_LIMIT_LOG2 = 20,
  localparam int SEL_W            = $clog2(NUM_WIN) + 1,
  localparam int IDX_W            = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrWin,
  input  logic [1:0]         wrSel,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic [SEL_W-1:0]   rdWin,
  input  logic [1:0]         rdSel,
  output logic [ADDR_W-1:0]  rdData,
  output logic [NUM_WIN-1:0] cfgErr,
  input  logic               inValid,
  input  logic [ADDR_W-1:0]  inAddr,
  output logic               outValid,
  output logic [ADDR_W-1:0]  outAddr,
  output logic               outHit,
  output logic               outMiss,
  output logic [IDX_W-1:0]   outWin
);

  localparam int GRAN = granuleBits(MIN_REGION);

  fieldStrobe_t                   strobe;
  logic [NUM_WIN-1:0]             winOneHot;
  logic [NUM_WIN-1:0][ADDR_W-1:0] baseArr;
  logic [NUM_WIN-1:0][ADDR_W-1:0] limitArr;
  logic [NUM_WIN-1:0][ADDR_W-1:0] targetArr;
  logic [NUM_WIN-1:0]             enArr;

  atu_ctrl #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) uCtrl (
    .wrEn(wrEn), .wrWin(wrWin), .wrSel(wrSel),
    .strobe(strobe), .winOneHot(winOneHot)
  );

  atu_regfile #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN(GRAN),
    .LIM_LOG2(REGION_LIMIT_LOG2), .SEL_W(SEL_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .winOneHot(winOneHot),
    .wrData(wrData), .rdWin(rdWin), .rdSel(rdSel), .rdData(rdData),
    .baseArr(baseArr), .limitArr(limitArr), .targetArr(targetArr),
    .enArr(enArr), .errArr(cfgErr)
  );

  atu_lookup #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uLook (
    .clk(clk), .rstN(rstN), .baseArr(baseArr), .limitArr(limitArr),
    .targetArr(targetArr), .enArr(enArr), .errArr(cfgErr),
    .inValid(inValid), .inAddr(inAddr), .outValid(outValid),
    .outAddr(outAddr), .outHit(outHit), .outMiss(outMiss), .outWin(outWin)
  );

endmodule

// File: rtl/atu_checker.sv
module atu_checker #(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_WIN-1:0] cfgErr,
  input logic               inValid,
  input logic [ADDR_W-1:0]  inAddr,
  input logic               outValid,
  input logic [ADDR_W-1:0]  outAddr,
  input logic               outHit,
  input logic               outMiss,
  input logic [IDX_W-1:0]   outWin
);

  logic [NUM_WIN-1:0] errPrev;
  always_ff @(posedge clk) begin
    if (!rstN) errPrev <= '0;
    else       errPrev <= cfgErr;
  end

  // R3 / R4: result appears exactly one cycle after a request
  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r4_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R3: hit and miss are mutually exclusive on every result
  a_r3_hit_xor_miss: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outHit != outMiss));
  // R4: a miss returns the request address
  a_r4_miss_passthru: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outMiss -> (outAddr == $past(inAddr))));
  // R6: a flagged window never wins
  a_r6_err_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHit) |-> !errPrev[outWin]);

endmodule

bind xlat_window_unit atu_checker #(
  .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) uChk (
  .clk(clk), .rstN(rstN), .cfgErr(cfgErr), .inValid(inValid),
  .inAddr(inAddr), .outValid(outValid), .outAddr(outAddr),
  .outHit(outHit), .outMiss(outMiss), .outWin(outWin)
);

// File: tb/tb_xlat_window_unit.sv
`timescale 1ns/1ps
module tb_xlat_window_unit;
  localparam int NW = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [2:0]    wrWin;
  logic [1:0]    wrSel;
  logic [AW-1:0] wrData;
  logic [2:0]    rdWin;
  logic [1:0]    rdSel;
  logic [AW-1:0] rdData;
  logic [NW-1:0] cfgErr;
  logic          inValid;
  logic [AW-1:0] inAddr;
  logic          outValid;
  logic [AW-1:0] outAddr;
  logic          outHit;
  logic          outMiss;
  logic [1:0]    outWin;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] mBase [NW];
  logic [AW-1:0] mLim  [NW];
  logic [AW-1:0] mTgt  [NW];
  logic [3:0]    mCtl  [NW];

  always #2.5 clk = ~clk;

  xlat_window_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWin(wrWin), .wrSel(wrSel),
    .wrData(wrData), .rdWin(rdWin), .rdSel(rdSel), .rdData(rdData),
    .cfgErr(cfgErr), .inValid(inValid), .inAddr(inAddr),
    .outValid(outValid), .outAddr(outAddr), .outHit(outHit),
    .outMiss(outMiss), .outWin(outWin)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic modelErr(input int i);
    return (mBase[i][11:0] != 0) || (mTgt[i][11:0] != 0) ||
           (mBase[i][31:20] != mLim[i][31:20]);
  endfunction

  task automatic wr(input int w, input int sel, input logic [AW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrWin = 3'(w); wrSel = 2'(sel); wrData = d;
    if (w < NW) begin
      case (sel)
        0: mBase[w] = d;
        1: mLim[w]  = d | 32'hFFF;
        2: mTgt[w]  = d;
        default: mCtl[w] = d[3:0];
      endcase
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [AW-1:0] a);
    logic          eHit;
    int            eWin;
    logic [AW-1:0] eAddr;
    eHit = 1'b0; eWin = 0; eAddr = a;
    for (int i = NW - 1; i >= 0; i--)
      if (mCtl[i][0] && !modelErr(i) && a >= mBase[i] && a <= mLim[i]) begin
        eHit = 1'b1; eWin = i; eAddr = mTgt[i] + (a - mBase[i]);
      end
    @(negedge clk);
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {31'd0, outValid}, 32'd1);
    check({req, " hit"},   {31'd0, outHit},   {31'd0, eHit});
    check({req, " miss"},  {31'd0, outMiss},  {31'd0, !eHit});
    check({req, " addr"},  outAddr, eAddr);
    if (eHit) check({req, " win"}, {30'd0, outWin}, 32'(eWin));
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < NW; i++) begin
      rdWin = 3'(i);
      rdSel = 2'd0; #0.1 check({req, " base"},   rdData, mBase[i]);
      rdSel = 2'd1; #0.1 check({req, " limit"},  rdData, mLim[i]);
      rdSel = 2'd2; #0.1 check({req, " target"}, rdData, mTgt[i]);
      rdSel = 2'd3; #0.1 check({req, " ctrl"},   rdData, {28'd0, mCtl[i]});
      check({req, " err"}, {31'd0, cfgErr[i]}, {31'd0, modelErr(i)});
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NW; i++) begin
      lookup(req, mBase[i] - 1); lookup(req, mBase[i]); lookup(req, mBase[i] + 1);
      lookup(req, mLim[i] - 1);  lookup(req, mLim[i]);  lookup(req, mLim[i] + 1);
    end
    for (int a = 0; a < 32'h60000; a += 32'h1800) lookup(req, 32'(a) + 32'h7F);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrWin = '0; wrSel = '0; wrData = '0;
    rdWin = '0; rdSel = '0; inValid = 1'b0; inAddr = '0;
    for (int i = 0; i < NW; i++) begin
      mBase[i] = '0; mLim[i] = 32'hFFF; mTgt[i] = '0; mCtl[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 outValid", {31'd0, outValid}, 32'd0);
    readAll("R1");
    lookup("R1 miss after reset", 32'h0000_0800);

    // R2: programming and readback, limit low bits forced
    wr(0, 0, 32'h0001_0000); wr(0, 1, 32'h0001_3ABC); wr(0, 2, 32'h8000_0000); wr(0, 3, 32'h1);
    wr(1, 0, 32'h0001_2000); wr(1, 1, 32'h0001_F000); wr(1, 2, 32'h9000_0000); wr(1, 3, 32'h5);
    wr(2, 0, 32'h0003_0000); wr(2, 1, 32'h0003_0800); wr(2, 2, 32'hA000_1000); wr(2, 3, 32'hF);
    wr(3, 0, 32'h0004_0000); wr(3, 1, 32'h0004_FFFF); wr(3, 2, 32'hB000_0000); wr(3, 3, 32'hE);
    readAll("R2");

    // R3 R5 R7 R10: translation, priority on overlap, disabled window 3, rounded limit of window 2
    sweep("R3 R5 R7 R10");
    lookup("R5 overlap", 32'h0001_3000);
    lookup("R10 granule end", 32'h0003_0FFF);
    lookup("R10 past end", 32'h0003_1000);
    lookup("R7 disabled", 32'h0004_1000);

    // R6: unaligned base
    wr(3, 3, 32'h1); wr(3, 0, 32'h0004_0800);
    readAll("R6 base");
    lookup("R6 base no hit", 32'h0004_1000);
    // R6: target unaligned
    wr(3, 0, 32'h0004_0000); wr(3, 2, 32'hB000_0010);
    readAll("R6 target");
    lookup("R6 target no hit", 32'h0004_1000);
    // R6: window crossing the 1 MiB boundary
    wr(3, 2, 32'hB000_0000); wr(3, 0, 32'h000F_0000); wr(3, 1, 32'h0010_FFFF);
    readAll("R6 span");
    lookup("R6 span no hit", 32'h000F_8000);
    // R6 cleared: valid again
    wr(3, 1, 32'h000F_FFFF);
    readAll("R6 fixed");
    lookup("R3 window3 hit", 32'h000F_8000);

    // R8: out-of-range index
    wr(4, 0, 32'h0000_0000); wr(5, 3, 32'h1); wr(7, 2, 32'h1234_5000);
    readAll("R8");
    rdWin = 3'd6; rdSel = 2'd0; #0.1 check("R8 read beyond", rdData, 32'd0);
    sweep("R8");

    // R9: write and lookup in the same cycle use old contents, next cycle new
    @(negedge clk);
    wrEn = 1'b1; wrWin = 3'd0; wrSel = 2'd2; wrData = 32'hC000_0000;
    inValid = 1'b1; inAddr = 32'h0001_0040;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9 old target", outAddr, 32'h8000_0040);
    inAddr = 32'h0001_0040;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 new target", outAddr, 32'hC000_0040);
    mTgt[0] = 32'hC000_0000;
    sweep("R9");

    // R1: reset clears again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < NW; i++) begin
      mBase[i] = '0; mLim[i] = 32'hFFF; mTgt[i] = '0; mCtl[i] = '0;
    end
    @(negedge clk);
    check("R1 outValid again", {31'd0, outValid}, 32'd0);
    readAll("R1 again");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule